// File: doc/BRIEF.md
# Attribute-Driven Cache Policy Controller

This block is a small direct-mapped cache controller placed between an upstream request port and a downstream next-level memory port. Every request carries a 4-bit cache attribute. The controller decodes that attribute for each transaction on its own, so each request has its own policy. The policy decides whether the request bypasses the cache, reads a resident line, fills a line, writes through, writes back with a dirty mark, or allocates on a write. The read-allocate and write-allocate hints are decoded independently of each other.

The cache holds `LINES` lines of `WORDS` words each. Each line has a tag, a valid bit and a dirty bit. Requests and downstream transfers are a whole line wide and carry a per-word write mask. Upstream writes are the entries a store buffer drains toward the controller. Strongly ordered writes arrive directly. The controller takes one request at a time. It finishes each request with a one-cycle response pulse.

Top module: `attr_cache_ctrl`

## Requirements
- R1: Attribute bits are: bit0 bufferable, bit1 cacheable, bit2 read-allocate, bit3 write-allocate. A request is treated as non-caching when bit1 is 0, or when both bit2 and bit3 are 0. A non-caching read does exactly one downstream read. It returns the downstream line even when that address is resident in the cache, and it reports no hit.
- R2: A non-caching write does exactly one downstream write with the request's address, data and mask. It leaves the cache contents unchanged.
- R3: A caching read that hits returns the resident line with the hit flag set and makes no downstream transfer.
- R4: A caching read that misses with read-allocate set fetches the line from downstream, installs it clean, and returns it. A later read of that address hits.
- R5: A caching read that misses with read-allocate clear does one downstream read and installs nothing.
- R6: A write hit with bufferable clear (write-through) merges the masked words into the line and also does one downstream write. It does not set the dirty bit.
- R7: A write hit with bufferable set (write-back) merges the masked words into the line and sets the dirty bit. It makes no downstream transfer.
- R8: A write miss with write-allocate clear does one downstream write and installs nothing.
- R9: A write miss with write-allocate set reads the line from downstream only when the mask is not all ones. It merges the write into the line and installs the line, dirty when write-back. In write-through it also does one downstream write.
- R10: When an allocation replaces a valid dirty line, the controller first writes that line downstream with a full mask at the line's own address. It does this before any fill read.
- R11: After reset, req_ready is 1 and resp_valid and mem_valid are 0. req_ready is low from acceptance until the response. resp_valid lasts one cycle. A downstream request holds its address, direction and mask until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Controller idle, request accepted when valid |
| req_write | input | 1 | 1 write, 0 read |
| req_attr | input | 4 | Cache attribute of the request |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | DATA_W*WORDS | Write line data |
| req_wmask | input | WORDS | Per-word write enable |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_hit | output | 1 | Request hit in the cache |
| resp_rdata | output | DATA_W*WORDS | Read line data |
| mem_valid | output | 1 | Downstream request valid |
| mem_ready | input | 1 | Downstream request accepted |
| mem_write | output | 1 | Downstream direction, 1 write |
| mem_addr | output | ADDR_W | Downstream line address |
| mem_wdata | output | DATA_W*WORDS | Downstream write data |
| mem_wmask | output | WORDS | Downstream per-word write enable |
| mem_rvalid | input | 1 | Downstream read data valid |
| mem_rdata | input | DATA_W*WORDS | Downstream read data |

## Verification
The bench uses the default build: four lines of four 16-bit words and an 8-bit line address. Stimulus stays within sixteen line addresses, so four tags compete for each index. At this size, dirty evictions, write-allocate after eviction and hits on lines written by earlier policies happen often in a few hundred requests. The downstream model adds random accept stalls and read latency. These delays exercise the hold rule on the downstream request and the eviction-before-fill order.

// File: rtl/attr_cache_ctrl.sv
module attr_cache_ctrl #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4,
  parameter int LINES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [3:0]                req_attr,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W*WORDS-1:0]   req_wdata,
  input  logic [WORDS-1:0]          req_wmask,
  output logic                      resp_valid,
  output logic                      resp_hit,
  output logic [DATA_W*WORDS-1:0]   resp_rdata,
  output logic                      mem_valid,
  input  logic                      mem_ready,
  output logic                      mem_write,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [DATA_W*WORDS-1:0]   mem_wdata,
  output logic [WORDS-1:0]          mem_wmask,
  input  logic                      mem_rvalid,
  input  logic [DATA_W*WORDS-1:0]   mem_rdata
);
  localparam int LINE_W = DATA_W * WORDS;
  localparam int IDX_W  = $clog2(LINES);
  localparam int TAG_W  = ADDR_W - IDX_W;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_EVICT, S_RDREQ, S_RDWAIT, S_UPD, S_WRDN, S_RESP
  } st_t;

  st_t st;
  logic              r_write, r_hit, r_fetch, r_inst, r_wr;
  logic [3:0]        r_attr;
  logic [ADDR_W-1:0] r_addr;
  logic [LINE_W-1:0] r_wdata, lbuf, merged;
  logic [WORDS-1:0]  r_mask;

  logic              v_q   [LINES];
  logic              d_q   [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] dat_q [LINES];

  wire [IDX_W-1:0] idx  = r_addr[IDX_W-1:0];
  wire [TAG_W-1:0] rtag = r_addr[ADDR_W-1:IDX_W];
  wire wback  = r_attr[0];
  wire byp    = !(r_attr[1] && (r_attr[2] || r_attr[3]));
  wire hit    = !byp && v_q[idx] && (tag_q[idx] == rtag);
  wire full   = &r_mask;
  wire vdirty = v_q[idx] && d_q[idx];

  always_comb begin
    for (int w = 0; w < WORDS; w++)
      merged[w*DATA_W +: DATA_W] = r_mask[w] ? r_wdata[w*DATA_W +: DATA_W]
                                             : lbuf[w*DATA_W +: DATA_W];
  end

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = (st == S_RESP);
  assign resp_hit   = r_hit;
  assign resp_rdata = lbuf;
  assign mem_valid  = (st == S_EVICT) || (st == S_RDREQ) || (st == S_WRDN);
  assign mem_write  = (st != S_RDREQ);
  assign mem_addr   = (st == S_EVICT) ? {tag_q[idx], idx} : r_addr;
  assign mem_wdata  = (st == S_EVICT) ? dat_q[idx] : r_wdata;
  assign mem_wmask  = (st == S_EVICT) ? '1 : ((st == S_RDREQ) ? '0 : r_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_hit   <= 1'b0;
      r_fetch <= 1'b0;
      r_inst  <= 1'b0;
      r_wr    <= 1'b0;
      r_attr  <= '0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_mask  <= '0;
      lbuf    <= '0;
      for (int i = 0; i < LINES; i++) begin
        v_q[i]   <= 1'b0;
        d_q[i]   <= 1'b0;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_write <= req_write;
          r_attr  <= req_attr;
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          r_mask  <= req_wmask;
          r_hit   <= 1'b0;
          r_fetch <= 1'b0;
          r_inst  <= 1'b0;
          r_wr    <= 1'b0;
          st      <= S_DEC;
        end
        S_DEC: begin
          r_hit <= hit;
          lbuf  <= dat_q[idx];
          if (!r_write) begin
            if (hit) st <= S_RESP;
            else if (!byp && r_attr[2]) begin
              r_inst  <= 1'b1;
              r_fetch <= 1'b1;
              st      <= vdirty ? S_EVICT : S_RDREQ;
            end else st <= S_RDREQ;
          end else begin
            if (hit) begin
              r_inst <= 1'b1;
              r_wr   <= !wback;
              st     <= S_UPD;
            end else if (!byp && r_attr[3]) begin
              r_inst  <= 1'b1;
              r_fetch <= !full;
              r_wr    <= !wback;
              st      <= vdirty ? S_EVICT : (full ? S_UPD : S_RDREQ);
            end else begin
              r_wr <= 1'b1;
              st   <= S_WRDN;
            end
          end
        end
        S_EVICT:  if (mem_ready) st <= r_fetch ? S_RDREQ : S_UPD;
        S_RDREQ:  if (mem_ready) st <= S_RDWAIT;
        S_RDWAIT: if (mem_rvalid) begin
          lbuf <= mem_rdata;
          st   <= r_inst ? S_UPD : S_RESP;
        end
        S_UPD: begin
          v_q[idx]   <= 1'b1;
          tag_q[idx] <= rtag;
          dat_q[idx] <= r_write ? merged : lbuf;
          d_q[idx]   <= r_write && (wback || (r_hit && d_q[idx]));
          lbuf       <= r_write ? merged : lbuf;
          st         <= r_wr ? S_WRDN : S_RESP;
        end
        S_WRDN:  if (mem_ready) st <= S_RESP;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/attr_cache_ctrl_chk.sv
module attr_cache_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_attr,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORDS-1:0]  mem_wmask
);
  logic [3:0] lat_attr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_attr <= '0;
    else if (req_valid && req_ready) lat_attr <= req_attr;
  end

  a_r11_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r11_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wmask)));

  a_r1_bypass_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !(lat_attr[1] && (lat_attr[2] || lat_attr[3]))) |-> !resp_hit);

  a_r11_no_mem_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_valid);
endmodule

bind attr_cache_ctrl attr_cache_ctrl_chk #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_attr(req_attr), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
  .mem_addr(mem_addr), .mem_wmask(mem_wmask)
);

// File: tb/attr_cache_ctrl_tb.sv
module attr_cache_ctrl_tb;
  localparam int ADDR_W = 8, DATA_W = 16, WORDS = 4, LINES = 4;
  localparam int LINE_W = DATA_W * WORDS;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_attr = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LINE_W-1:0] req_wdata = '0;
  logic [WORDS-1:0] req_wmask = '0;
  logic req_ready, resp_valid, resp_hit;
  logic [LINE_W-1:0] resp_rdata;
  logic mem_valid, mem_write;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [LINE_W-1:0] mem_wdata;
  logic [LINE_W-1:0] mem_rdata = '0;
  logic [WORDS-1:0] mem_wmask;

  attr_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .LINES(LINES)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_attr(req_attr), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_wmask(req_wmask), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_rdata(resp_rdata), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  always #5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, rd_cnt = -1;
  bit first_set = 1'b0, first_wr = 1'b0;
  logic [ADDR_W-1:0] rd_a;
  logic [LINE_W-1:0] bmem [256];
  logic [LINE_W-1:0] refmem [256];
  logic rv [LINES], rdty [LINES];
  logic [5:0] rt [LINES];
  logic [LINE_W-1:0] rdat [LINES];

  function automatic logic [LINE_W-1:0] mrg(logic [LINE_W-1:0] base, logic [LINE_W-1:0] d,
                                            logic [WORDS-1:0] m);
    logic [LINE_W-1:0] r = base;
    for (int w = 0; w < WORDS; w++) if (m[w]) r[w*DATA_W +: DATA_W] = d[w*DATA_W +: DATA_W];
    return r;
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_rvalid = 1'b0;
    if (!rst_n) begin
      mem_ready = 1'b0;
      rd_cnt = -1;
    end else begin
      if (rd_cnt == 0) begin
        mem_rvalid = 1'b1;
        mem_rdata = bmem[rd_a];
        rd_cnt = -1;
      end else if (rd_cnt > 0) rd_cnt--;
      mem_ready = ($urandom % 4) != 0;
      if (mem_valid && mem_ready) begin
        if (!first_set) begin first_set = 1'b1; first_wr = mem_write; end
        if (mem_write) begin
          n_wr++;
          bmem[mem_addr] = mrg(bmem[mem_addr], mem_wdata, mem_wmask);
        end else begin
          n_rd++;
          rd_a = mem_addr;
          rd_cnt = $urandom % 3;
        end
      end
    end
  end

  task automatic do_req(bit wr, logic [3:0] at, logic [ADDR_W-1:0] a,
                        logic [LINE_W-1:0] d, logic [WORDS-1:0] m);
    bit byp, hit, vd, ev, full;
    int erd = 0, ewr = 0;
    logic [1:0] ix = a[1:0];
    logic [5:0] tg = a[7:2];
    logic [LINE_W-1:0] edata = '0, base;
    string rq;
    byp  = !(at[1] && (at[2] || at[3]));
    hit  = !byp && rv[ix] && rt[ix] == tg;
    vd   = rv[ix] && rdty[ix];
    full = &m;
    ev   = 1'b0;
    if (!wr) begin
      if (byp) begin erd = 1; edata = refmem[a]; rq = "R1"; end
      else if (hit) begin edata = rdat[ix]; rq = "R3"; end
      else if (at[2]) begin
        if (vd) begin ev = 1'b1; ewr = 1; refmem[{rt[ix], ix}] = rdat[ix]; end
        erd = 1; rv[ix] = 1'b1; rt[ix] = tg; rdty[ix] = 1'b0; rdat[ix] = refmem[a];
        edata = rdat[ix]; rq = ev ? "R10" : "R4";
      end else begin erd = 1; edata = refmem[a]; rq = "R5"; end
    end else begin
      if (byp) begin ewr = 1; refmem[a] = mrg(refmem[a], d, m); rq = "R2"; end
      else if (hit) begin
        rdat[ix] = mrg(rdat[ix], d, m);
        if (at[0]) rdty[ix] = 1'b1;
        else begin ewr = 1; refmem[a] = mrg(refmem[a], d, m); end
        rq = at[0] ? "R7" : "R6";
      end else if (at[3]) begin
        if (vd) begin ev = 1'b1; ewr = 1; refmem[{rt[ix], ix}] = rdat[ix]; end
        base = refmem[a];
        if (!full) erd = 1;
        rv[ix] = 1'b1; rt[ix] = tg; rdty[ix] = at[0]; rdat[ix] = mrg(base, d, m);
        if (!at[0]) begin ewr++; refmem[a] = mrg(refmem[a], d, m); end
        rq = ev ? "R10" : "R9";
      end else begin ewr = 1; refmem[a] = mrg(refmem[a], d, m); rq = "R8"; end
    end
    @(negedge clk);
    n_rd = 0; n_wr = 0; first_set = 1'b0;
    req_valid = 1'b1; req_write = wr; req_attr = at; req_addr = a; req_wdata = d; req_wmask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11", "busy req_ready", LINE_W'(req_ready), '0);
    while (!resp_valid) @(negedge clk);
    chk(resp_hit == hit, rq, "hit", LINE_W'(resp_hit), LINE_W'(hit));
    chk(n_rd == erd, rq, "downstream reads", LINE_W'(n_rd), LINE_W'(erd));
    chk(n_wr == ewr, rq, "downstream writes", LINE_W'(n_wr), LINE_W'(ewr));
    if (!wr) chk(resp_rdata == edata, rq, "read data", resp_rdata, edata);
    if (ev) chk(first_set && first_wr, "R10", "eviction first", LINE_W'(first_wr), 1);
    @(negedge clk);
    chk(!resp_valid, "R11", "response pulse", LINE_W'(resp_valid), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      bmem[i] = LINE_W'(i) * 64'h0103_0507_0b0d_1113 + 64'h5a;
      refmem[i] = bmem[i];
    end
    for (int i = 0; i < LINES; i++) begin
      rv[i] = 1'b0; rdty[i] = 1'b0; rt[i] = '0; rdat[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !mem_valid, "R11", "reset state",
        {req_ready, resp_valid, mem_valid}, 3'b100);
    rst_n = 1'b1;
    do_req(0, 4'b1111, 8'h01, '0, '0);                       // R4 fill
    do_req(0, 4'b1111, 8'h01, '0, '0);                       // R3 hit
    do_req(1, 4'b1111, 8'h01, 64'h1111_2222_3333_4444, 4'b0001); // R7 dirty
    do_req(0, 4'b0000, 8'h01, '0, '0);                       // R1 bypass read
    do_req(1, 4'b0001, 8'h01, 64'hdead_beef_cafe_f00d, 4'b1111); // R2 device write
    do_req(0, 4'b1111, 8'h01, '0, '0);                       // R2 cache untouched
    do_req(0, 4'b0111, 8'h05, '0, '0);                       // R10 evict then fill
    do_req(0, 4'b1011, 8'h09, '0, '0);                       // R5 no install
    do_req(0, 4'b1011, 8'h09, '0, '0);                       // R5 misses again
    do_req(1, 4'b1011, 8'h02, 64'h0a0a_0b0b_0c0c_0d0d, 4'b0011); // R9 partial, fetch
    do_req(1, 4'b1010, 8'h03, 64'h7777_8888_9999_aaaa, 4'b1111); // R9 full, write-through
    do_req(1, 4'b0110, 8'h03, 64'h1234_5678_9abc_def0, 4'b0100); // R6 write-through hit
    do_req(1, 4'b0110, 8'h0c, 64'h4321_4321_4321_4321, 4'b1111); // R8 no allocate
    do_req(1, 4'b1011, 8'h06, 64'h5555_5555_5555_5555, 4'b1111); // R10 evict on write-allocate
    for (int k = 0; k < 400; k++) begin
      logic [3:0] m = (($urandom % 3) == 0) ? 4'hf : 4'($urandom);
      do_req(1'($urandom), 4'($urandom), 8'($urandom % 16), {$urandom, $urandom}, m);
    end
    begin
      bit same = 1'b1;
      for (int i = 0; i < 256; i++) if (bmem[i] !== refmem[i]) same = 1'b0;
      chk(same, "R2", "downstream memory image", LINE_W'(same), 1);
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule